// File: doc/BRIEF.md
# Triggered Capture Scope

The block is a small logic analyser that hangs off a register bus as a slave. On every clock it stores a 32-bit probe word into a circular on-chip buffer, so the buffer always holds the most recent history. Once the buffer has been filled completely at least once, a trigger pulse is accepted. The scope then stores a programmed number of further words and freezes. Software sees the result through two registers. The control register shows the capture state and the buffer size. The data register hands back the frozen history one word per read, oldest word first.

A typical use is to tie the trigger to the access strobe of some other memory on the same bus, so that any access to that memory freezes a trace around the event. To re-arm the scope, software writes the control register. That one write also loads the post-trigger count, clears all state flags and restarts recording from an empty buffer.

Top module: `capture_scope`

## Requirements
- R1: After reset the control register reads 0x0050_0000: all flags clear, depth exponent 5 and post-trigger count 0.
- R2: The bus has two registers, selected by `bus_addr`: 0 is control and 1 is data. In the control register, bit 31 and bits 27:25 always read 0, bit 28 is the primed flag, bit 29 the triggered flag and bit 30 the stopped flag. Bits 24:20 hold log2 of the buffer depth and bits 19:0 hold the post-trigger count.
- R3: After 2^AW words have been recorded since the last re-arm, the primed flag is set, so the top nibble of the control register reads 1.
- R4: A trigger pulse that arrives while the primed flag is clear has no effect.
- R5: A trigger while primed sets the triggered flag. The word sampled in the trigger cycle is stored, then exactly the programmed number of further words is stored, and then the stopped flag is set (top nibble 7).
- R6: With a post-trigger count of 0, the word sampled in the trigger cycle is the newest word in the frozen buffer.
- R7: Once stopped, each data-register read returns the next stored word, starting with the oldest. After 2^AW reads the sequence wraps back to the oldest word.
- R8: A data-register read before the stop returns 0 and does not disturb the capture.
- R9: Once stopped, further triggers and probe changes leave the flags, the buffer contents and the read position unchanged.
- R10: A write to the control register clears all three flags, loads bits 19:0 as the post-trigger count and restarts recording. It takes precedence over a trigger in the same cycle, and it also works in the middle of a post-trigger run.
- R11: Every read or write strobe is acknowledged in the next cycle, and read data is valid together with that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | 32 | Word recorded every cycle while the scope runs |
| trig_i | input | 1 | Trigger pulse |
| bus_stb | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after the strobe |
| bus_rdata | output | 32 | Read data, valid with the acknowledge |

## Verification
The probe carries a running count, so each expected readout word follows from the trigger-cycle value and the post-trigger count. An off-by-one in the post-trigger count therefore shows up as every readout word shifted by one. Three stimuli go after the state flags:
- An early trigger before the buffer has filled. A design that accepted it would report nibble 3 or 7 where 1 is expected.
- A re-arm write issued together with a trigger. A design that let the trigger win would report the triggered flag.
- A re-arm in the middle of a post-trigger run. A design that kept the old state would leave the triggered flag set.

The post-trigger counts are random, plus a count of zero. Reads run past the buffer length, which exposes a wrong read start or a missing wrap. A trigger sent after the stop exposes a buffer that keeps recording once frozen.

// File: rtl/scope_pkg.sv
package scope_pkg;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_DATA = 1'b1;

    localparam int BIT_PRIMED = 28;
    localparam int BIT_TRIGGERED = 29;
    localparam int BIT_STOPPED = 30;
    localparam int DEPTH_LSB = 20;
    localparam int DEPTH_FW = 5;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_ZERO = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/scope_ctrl.sv
module scope_ctrl #(
    parameter int AW = 5,
    parameter int HW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic          arm_i,
    input  logic [HW-1:0] hold_i,
    input  logic          rd_adv_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wptr_o,
    output logic [AW-1:0] rptr_o,
    output logic          primed_o,
    output logic          trg_o,
    output logic          stp_o,
    output logic [HW-1:0] hold_o
);

    localparam logic [AW-1:0] LAST_IDX = AW'((1 << AW) - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic          primed;
        logic          trg;
        logic          stp;
        logic [HW-1:0] cnt;
        logic [HW-1:0] hold;
    } st_t;

    st_t st_d, st_q;
    logic wr_en_d;

    always_comb begin
        st_d    = st_q;
        wr_en_d = 1'b0;
        if (arm_i) begin
            st_d.wptr   = '0;
            st_d.rptr   = '0;
            st_d.primed = 1'b0;
            st_d.trg    = 1'b0;
            st_d.stp    = 1'b0;
            st_d.cnt    = '0;
            st_d.hold   = hold_i;
        end else if (!st_q.stp) begin
            if (st_q.trg && st_q.cnt == '0) begin
                st_d.stp  = 1'b1;
                st_d.rptr = st_q.wptr;
            end else begin
                wr_en_d   = 1'b1;
                st_d.wptr = st_q.wptr + 1'b1;
                if (st_q.wptr == LAST_IDX) begin
                    st_d.primed = 1'b1;
                end
                if (st_q.trg) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (trig_i && st_q.primed) begin
                    st_d.trg = 1'b1;
                    st_d.cnt = st_q.hold;
                end
            end
        end else if (rd_adv_i) begin
            st_d.rptr = st_q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o  = wr_en_d;
    assign wptr_o   = st_q.wptr;
    assign rptr_o   = st_q.rptr;
    assign primed_o = st_q.primed;
    assign trg_o    = st_q.trg;
    assign stp_o    = st_q.stp;
    assign hold_o   = st_q.hold;

    AST_TRIG_NEEDS_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.trg) |-> $past(st_q.primed)); // R4

    AST_STOP_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stp |-> st_q.trg); // R5

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trg && !st_q.stp && st_q.cnt != '0 && !arm_i)
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R5

    AST_FROZEN_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stp && !arm_i) |=> ($stable(st_q.wptr) && st_q.stp)); // R9

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (!st_q.primed && !st_q.trg && !st_q.stp)); // R10

endmodule

// File: rtl/scope_mem.sv
module scope_mem #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] ram_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            ram_q[waddr_i] <= wdata_i;
        end
        rdata_q <= ram_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/scope_bus.sv
module scope_bus
    import scope_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5,
    parameter int HW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_i,
    input  logic          we_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          primed_i,
    input  logic          trg_i,
    input  logic          stp_i,
    input  logic [HW-1:0] hold_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          arm_o,
    output logic [HW-1:0] hold_o,
    output logic          rd_adv_o,
    output logic          ack_o,
    output logic [DW-1:0] rdata_o
);

    localparam int PAD_W = DEPTH_LSB - HW;
    localparam int MID_W = BIT_PRIMED - DEPTH_LSB - DEPTH_FW;

    typedef struct packed {
        logic          ack;
        rd_sel_e       sel;
        logic [DW-1:0] ctrl;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] ctrl_word;
    logic          rd_req;
    logic          unused_wbits;

    assign unused_wbits = ^wdata_i[DW-1:HW];

    generate
        if (PAD_W > 0) begin : g_pad
            assign ctrl_word = {1'b0, stp_i, trg_i, primed_i, {MID_W{1'b0}},
                                DEPTH_FW'(AW), {PAD_W{1'b0}}, hold_i};
        end else begin : g_nopad
            assign ctrl_word = {1'b0, stp_i, trg_i, primed_i, {MID_W{1'b0}},
                                DEPTH_FW'(AW), hold_i};
        end
    endgenerate

    assign rd_req   = stb_i && !we_i;
    assign arm_o    = stb_i && we_i && (addr_i == REG_CTRL);
    assign hold_o   = wdata_i[HW-1:0];
    assign rd_adv_o = rd_req && (addr_i == REG_DATA) && stp_i;

    always_comb begin
        st_d     = st_q;
        st_d.ack = stb_i;
        if (rd_req) begin
            if (addr_i == REG_CTRL) begin
                st_d.sel  = SEL_CTRL;
                st_d.ctrl = ctrl_word;
            end else if (stp_i) begin
                st_d.sel = SEL_DATA;
            end else begin
                st_d.sel = SEL_ZERO;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ack: 1'b0, sel: SEL_ZERO, ctrl: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.sel)
            SEL_CTRL: rdata_o = st_q.ctrl;
            SEL_DATA: rdata_o = mem_rdata_i;
            default:  rdata_o = '0;
        endcase
    end

    assign ack_o = st_q.ack;

    AST_ACK_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(stb_i)); // R11

    AST_STB_GETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> ack_o); // R11

    AST_EARLY_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && addr_i == REG_DATA && !stp_i) |=> (rdata_o == '0)); // R8

    AST_CTRL_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && st_q.sel == SEL_CTRL) |-> (rdata_o[DW-1] == 1'b0)); // R2

endmodule

// File: rtl/capture_scope.sv
module capture_scope #(
    parameter int DW = 32,
    parameter int AW = 5,
    parameter int HW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] probe_i,
    input  logic          trig_i,
    input  logic          bus_stb,
    input  logic          bus_we,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_ack,
    output logic [DW-1:0] bus_rdata
);

    logic          arm;
    logic [HW-1:0] hold_wr;
    logic [HW-1:0] hold_cur;
    logic          rd_adv;
    logic          wr_en;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          primed;
    logic          trg;
    logic          stp;
    logic [DW-1:0] mem_rdata;

    scope_ctrl #(.AW(AW), .HW(HW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .arm_i    (arm),
        .hold_i   (hold_wr),
        .rd_adv_i (rd_adv),
        .wr_en_o  (wr_en),
        .wptr_o   (wptr),
        .rptr_o   (rptr),
        .primed_o (primed),
        .trg_o    (trg),
        .stp_o    (stp),
        .hold_o   (hold_cur)
    );

    scope_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (wptr),
        .wdata_i (probe_i),
        .raddr_i (rptr),
        .rdata_o (mem_rdata)
    );

    scope_bus #(.DW(DW), .AW(AW), .HW(HW)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (bus_stb),
        .we_i        (bus_we),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .primed_i    (primed),
        .trg_i       (trg),
        .stp_i       (stp),
        .hold_i      (hold_cur),
        .mem_rdata_i (mem_rdata),
        .arm_o       (arm),
        .hold_o      (hold_wr),
        .rd_adv_o    (rd_adv),
        .ack_o       (bus_ack),
        .rdata_o     (bus_rdata)
    );

    AST_NO_STORE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stp |-> !wr_en); // R9

    AST_READ_ONLY_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |-> stp); // R8

endmodule

// File: tb/sim_capture_scope.sv
`timescale 1ns/1ps
module sim_capture_scope;

    localparam int AW = 5;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        stb = 1'b0;
    logic        we = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic [31:0] cyc = '0;
    logic [31:0] base = 32'h5A00_0000;
    logic [31:0] probe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign probe = base + cyc;

    capture_scope u0 (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .trig_i(trig),
        .bus_stb(stb), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_ack(ack), .bus_rdata(rdata)
    );

    function automatic logic [31:0] exp_ctrl(input logic [3:0] nib, input logic [19:0] h);
        return {nib, 3'b000, 5'(AW), h};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d, output logic k);
        stb = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        k = ack; d = rdata;
        stb = 1'b0;
    endtask

    task automatic bus_write(input logic [31:0] d, input logic with_trig);
        stb = 1'b1; we = 1'b1; addr = 1'b0; wdata = d; trig = with_trig;
        @(negedge clk);
        stb = 1'b0; we = 1'b0; trig = 1'b0;
    endtask

    task automatic pulse_trig(output logic [31:0] tval);
        trig = 1'b1; tval = probe;
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        k;
        logic [31:0] t;
        logic [19:0] h;
        logic [31:0] oldest;
        void'($urandom(32'h00C0FFEE));
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state, R11 ack timing, R2 layout
        bus_read(1'b0, d, k);
        check("R1", d, 32'h0050_0000);
        check("R11", {31'b0, k}, 32'd1);
        check("R2", {27'b0, d[24:20]}, 32'd5);
        // R8 data read before any stop
        bus_read(1'b1, d, k);
        check("R8", d, 32'h0);

        for (int it = 0; it < 4; it++) begin
            h = (it == 0) ? 20'd0 : 20'($urandom_range(1, 60));
            bus_write({12'hFFF, h}, 1'b0);
            bus_read(1'b0, d, k);
            check("R10", d, exp_ctrl(4'h0, h));
            pulse_trig(t); // R4 early trigger must be ignored
            tick(DEPTH + 2);
            bus_read(1'b0, d, k);
            check("R3", d, exp_ctrl(4'h1, h));
            check("R4", {28'b0, d[31:28]}, 32'h1);
            bus_read(1'b1, d, k);
            check("R8", d, 32'h0);
            tick($urandom_range(0, 20));
            pulse_trig(t);
            tick(int'(h) + 4);
            bus_read(1'b0, d, k);
            check((it == 0) ? "R6" : "R5", d, exp_ctrl(4'h7, h));
            oldest = t + 32'(h) - DEPTH + 1;
            for (int j = 0; j <= DEPTH; j++) begin
                bus_read(1'b1, d, k);
                check((it == 0) ? "R6" : "R7", d, oldest + 32'(j % DEPTH));
                check("R11", {31'b0, k}, 32'd1);
            end
            pulse_trig(t);
            tick(5);
            bus_read(1'b0, d, k);
            check("R9", d, exp_ctrl(4'h7, h));
            bus_read(1'b1, d, k);
            check("R9", d, oldest + 32'd1);
        end

        // R10 re-arm wins over a simultaneous trigger (previous state primed)
        bus_write(32'd9, 1'b1);
        bus_read(1'b0, d, k);
        check("R10", d, exp_ctrl(4'h0, 20'd9));
        tick(DEPTH + 2);
        bus_read(1'b0, d, k);
        check("R10", d, exp_ctrl(4'h1, 20'd9));

        // R10 re-arm in the middle of a long post-trigger run
        bus_write(32'd1000, 1'b0);
        tick(DEPTH + 2);
        pulse_trig(t);
        tick(10);
        bus_read(1'b0, d, k);
        check("R5", d, exp_ctrl(4'h3, 20'd1000));
        bus_write(32'd2, 1'b0);
        bus_read(1'b0, d, k);
        check("R10", d, exp_ctrl(4'h0, 20'd2));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule